// File: doc/BRIEF.md
# Banked Scalar Scratch Memory

This block is the private scratch SRAM of one scalar core. The core's register file reads and writes 32-bit words through it. Register spills go here, and so do argument tables and small control records. Each request names a word, never a byte. The word is either a 16-bit unsigned immediate or the sum of a 32-bit signed base register value and a 16-bit signed displacement. The block turns the word index into a byte address once, by multiplying it by four, and range-checks that byte address against the configured size. Accesses in range go to one of eight word-interleaved banks.

Loads return on a response port exactly six cycles after the issue cycle. Each response carries the destination register tag, and responses keep issue order. An address outside the array raises a fault, and the fault code tells a negative address apart from one that is too large. A faulting request never touches the array. A faulting load still answers on time, with zero data. A faulting store reports its code on a separate port one cycle after issue. Reset does not clear the array, so software must write a word before it depends on the value.

Top module: `scalar_scratch_mem`

## Requirements
- R1: Opcode 0 (absolute load) and opcode 2 (absolute store) address the word given by the unsigned 16-bit immediate. A store followed later by a load of that word returns the stored 32-bit value.
- R2: Opcode 1 (displaced load) addresses the word base + sign-extended immediate, where base is a signed 32-bit value. For example, base 10 with displacement -3 reads word 7.
- R3: Word w sits in bank w mod 8 at row w / 8. Any in-range access enables exactly one bank, and distinct words never alias.
- R4: A load sampled at clock edge k raises rsp_valid for exactly the one cycle that follows edge k+5, which is six cycles after the issue cycle. rsp_valid is low at all other times.
- R5: Load responses come back in issue order, and each carries the request's tag on rsp_tag.
- R6: When byte address = 4 × word index is below 0, the load returns rsp_fault = 1 with rsp_data = 0.
- R7: When the byte address is at or above SIZE_BYTES, the access faults with code 2. Word SIZE_BYTES/4 − 1 is valid and word SIZE_BYTES/4 faults. Code 3 is never produced.
- R8: A store sampled at edge k drives its fault code (0 none, 1 negative, 2 too large) on st_fault in the cycle after edge k. st_fault is 0 otherwise.
- R9: A faulting access does not write the array. A store to word SIZE_BYTES/4 leaves word 0 unchanged.
- R10: Reset clears the pipeline and the handshake but not the array. A word written before reset reads back unchanged after reset.
- R11: A load issued in the cycle after a store to the same word returns the new value. A load issued in the cycle before that store returns the old value.
- R12: Opcode 3 is ignored. It produces no response, no write and no store fault.
- R13: req_ready is low while reset is asserted and goes high at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_op | input | 2 | 0 absolute load, 1 displaced load, 2 absolute store, 3 ignored |
| req_imm | input | 16 | Word index (absolute forms) or signed displacement (opcode 1) |
| req_base | input | 32 | Signed base word index for opcode 1 |
| req_wdata | input | 32 | Store data |
| req_tag | input | TAG_W | Destination register tag of a load |
| rsp_valid | output | 1 | Load response present |
| rsp_tag | output | TAG_W | Tag of the returning load |
| rsp_data | output | 32 | Loaded word, zero on a fault |
| rsp_fault | output | 2 | 0 in range, 1 negative, 2 too large |
| st_fault | output | 2 | Fault code of the store issued one cycle earlier |

## Verification
Some properties hold on every clock, and the assertions check those. An accepted load is followed six cycles later by exactly one response, and no response appears without one. At most one bank is enabled at a time, and it is the bank named by the word's low bits. A faulting or ignored request enables no bank. A faulted response carries zero data, and a store fault only follows a store. Other behaviours can only be shown by the bench scenarios:

- data returning from the right word, with no aliasing across banks;
- the arithmetic of the displaced form;
- the exact boundary between valid and oversize words;
- the ordering of a store and a load in adjacent cycles;
- contents surviving a reset.

// File: rtl/sspad_pkg.sv
package sspad_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WIDX_W     = 34;  // signed word index: 32-bit base plus carry room
  localparam int BADDR_W    = 36;  // signed byte address

  typedef enum logic [1:0] {
    OP_LD_ABS = 2'd0,
    OP_LD_REL = 2'd1,
    OP_ST_ABS = 2'd2,
    OP_NONE   = 2'd3
  } sspad_op_e;

  typedef enum logic [1:0] {
    FLT_OK  = 2'd0,
    FLT_NEG = 2'd1,
    FLT_BIG = 2'd2
  } sspad_flt_e;

  // Unsigned immediate taken directly as a word index.
  function automatic logic signed [WIDX_W-1:0] abs_word(input logic [15:0] imm);
    return $signed({18'd0, imm});
  endfunction

  // Signed base plus signed 16-bit displacement, both in words.
  function automatic logic signed [WIDX_W-1:0] rel_word(input logic [31:0] base,
                                                        input logic [15:0] disp);
    return $signed({{2{base[31]}}, base}) + $signed({{18{disp[15]}}, disp});
  endfunction

  // The single word-to-byte conversion.
  function automatic logic signed [BADDR_W-1:0] word_to_byte(input logic signed [WIDX_W-1:0] w);
    return $signed({w, 2'b00});
  endfunction

  function automatic sspad_flt_e range_check(input logic signed [BADDR_W-1:0] b,
                                             input int size_bytes);
    if (b[BADDR_W-1]) return FLT_NEG;
    if (b[BADDR_W-2:0] >= (BADDR_W-1)'(size_bytes)) return FLT_BIG;
    return FLT_OK;
  endfunction

endpackage

// File: rtl/sspad_addr.sv
module sspad_addr
  import sspad_pkg::*;
#(
  parameter int SIZE_BYTES = 4096,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 7
) (
  input  sspad_op_e                 op,
  input  logic [15:0]               imm,
  input  logic [31:0]               base,
  output logic signed [WIDX_W-1:0]  word,
  output logic [BANK_W-1:0]         bank,
  output logic [ROW_W-1:0]          row,
  output sspad_flt_e                fault
);

  always_comb begin
    word  = (op == OP_LD_REL) ? rel_word(base, imm) : abs_word(imm);
    fault = range_check(word_to_byte(word), SIZE_BYTES);
    bank  = word[BANK_W-1:0];
    row   = word[BANK_W +: ROW_W];
  end

endmodule

// File: rtl/sspad_bank.sv
module sspad_bank #(
  parameter int ROWS  = 128,
  parameter int ROW_W = 7,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  // No reset: contents persist across reset by design.
  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end

endmodule

// File: rtl/sspad_lat.sv
module sspad_lat #(
  parameter int W     = 40,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stg
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= d;
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/scalar_scratch_mem.sv
module scalar_scratch_mem
  import sspad_pkg::*;
#(
  parameter int SIZE_BYTES = 4096,
  parameter int BANKS      = 8,
  parameter int LATENCY    = 6,
  parameter int TAG_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_imm,
  input  logic [31:0]      req_base,
  input  logic [31:0]      req_wdata,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  output logic [TAG_W-1:0] rsp_tag,
  output logic [31:0]      rsp_data,
  output logic [1:0]       rsp_fault,
  output logic [1:0]       st_fault
);

  localparam int WORDS  = SIZE_BYTES / WORD_BYTES;
  localparam int ROWS   = WORDS / BANKS;
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int RSP_W  = 1 + 2 + TAG_W + 32;

  sspad_op_e op;
  assign op = sspad_op_e'(req_op);

  // Named events of the issue stage.
  logic                     acc_fire, acc_ld, acc_st, acc_hit;
  logic signed [WIDX_W-1:0] acc_word;
  logic [BANK_W-1:0]        acc_bank;
  logic [ROW_W-1:0]         acc_row;
  sspad_flt_e               acc_fault;
  logic [BANKS-1:0]         bank_en;
  logic [31:0]              bank_rd [BANKS];

  logic ready_q;
  assign req_ready = ready_q;

  assign acc_fire = req_valid && ready_q && (op != OP_NONE);
  assign acc_ld   = acc_fire && (op == OP_LD_ABS || op == OP_LD_REL);
  assign acc_st   = acc_fire && (op == OP_ST_ABS);
  assign acc_hit  = acc_fire && (acc_fault == FLT_OK);

  sspad_addr #(.SIZE_BYTES(SIZE_BYTES), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_addr (
    .op    (op),
    .imm   (req_imm),
    .base  (req_base),
    .word  (acc_word),
    .bank  (acc_bank),
    .row   (acc_row),
    .fault (acc_fault)
  );

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      assign bank_en[b] = acc_hit && (acc_bank == BANK_W'(b));
      sspad_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .DW(32)) u_bank (
        .clk   (clk),
        .en    (bank_en[b]),
        .we    (acc_st),
        .row   (acc_row),
        .wdata (req_wdata),
        .rdata (bank_rd[b])
      );
    end
  endgenerate

  // First latency stage: the bank read itself.
  logic              s1_valid;
  logic [TAG_W-1:0]  s1_tag;
  sspad_flt_e        s1_fault;
  logic [BANK_W-1:0] s1_bank;
  sspad_flt_e        st_flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      s1_valid <= 1'b0;
      s1_tag   <= '0;
      s1_fault <= FLT_OK;
      s1_bank  <= '0;
      st_flt_q <= FLT_OK;
    end else begin
      ready_q  <= 1'b1;
      s1_valid <= acc_ld;
      s1_tag   <= req_tag;
      s1_fault <= acc_ld ? acc_fault : FLT_OK;
      s1_bank  <= acc_bank;
      st_flt_q <= acc_st ? acc_fault : FLT_OK;
    end
  end

  logic [31:0] s1_data;
  assign s1_data = (s1_valid && s1_fault == FLT_OK) ? bank_rd[s1_bank] : '0;

  // Remaining stages carry the response unchanged.
  logic [RSP_W-1:0] pipe_q;

  sspad_lat #(.W(RSP_W), .DEPTH(LATENCY - 1)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({s1_valid, s1_fault, s1_tag, s1_data}),
    .q     (pipe_q)
  );

  assign {rsp_valid, rsp_fault, rsp_tag, rsp_data} = pipe_q;
  assign st_fault = st_flt_q;

endmodule

// File: rtl/sspad_chk.sv
module sspad_chk #(
  parameter int LATENCY = 6,
  parameter int BANKS   = 8,
  parameter int BANK_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              acc_fire,
  input logic              acc_ld,
  input logic              acc_st,
  input logic [1:0]        acc_fault,
  input logic [BANKS-1:0]  bank_en,
  input logic [BANK_W-1:0] acc_bank,
  input logic              rsp_valid,
  input logic [1:0]        rsp_fault,
  input logic [31:0]       rsp_data,
  input logic [1:0]        st_fault
);

  // History of accepted loads, one bit per cycle.
  logic [LATENCY-1:0] ld_hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_hist <= '0;
    else        ld_hist <= {ld_hist[LATENCY-2:0], acc_ld};
  end

  // R4
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == ld_hist[LATENCY-1]);

  // R7
  rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_data == 32'd0);

  // R3
  bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));

  // R3
  bank_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_en) |-> bank_en[acc_bank]);

  // R9
  no_fault_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_fault != 2'd0) |-> bank_en == '0);

  // R8
  store_fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault != 2'd0 |-> $past(acc_st));

  // R12
  ignored_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |-> (bank_en == '0 && !acc_fire));

endmodule

bind scalar_scratch_mem sspad_chk #(
  .LATENCY (LATENCY),
  .BANKS   (BANKS),
  .BANK_W  (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .acc_fire  (acc_fire),
  .acc_ld    (acc_ld),
  .acc_st    (acc_st),
  .acc_fault (acc_fault),
  .bank_en   (bank_en),
  .acc_bank  (acc_bank),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_data  (rsp_data),
  .st_fault  (st_fault)
);

// File: tb/scalar_scratch_mem_test.sv
module scalar_scratch_mem_test;

  localparam int SIZE  = 4096;
  localparam int LAT   = 6;
  localparam int TW    = 5;
  localparam int WORDS = SIZE / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [15:0]   req_imm = '0;
  logic [31:0]   req_base = '0;
  logic [31:0]   req_wdata = '0;
  logic [TW-1:0] req_tag = '0;
  logic          rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [31:0]   rsp_data;
  logic [1:0]    rsp_fault;
  logic [1:0]    st_fault;

  always #4 clk = ~clk;  // 125 MHz

  scalar_scratch_mem #(.SIZE_BYTES(SIZE), .BANKS(8), .LATENCY(LAT), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_imm(req_imm), .req_base(req_base), .req_wdata(req_wdata),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault), .st_fault(st_fault)
  );

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string scen = "R13";

  typedef struct {
    int          due;
    int          tag;
    int          flt;
    logic [31:0] data;
    bit          known;
    string       lab;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mm [int];
  bit          exp_ready = 1'b0;
  int          exp_stf = 0;
  string       stf_lab = "R8";

  function automatic logic [31:0] pat(input int w);
    return 32'hC0DE_0000 + 32'(w) * 32'd7919;
  endfunction

  task automatic chk(input bit ok, input string lab, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", lab, what, act, exp);
    end
  endtask

  // Reference model: advances at each rising edge.
  longint mw, mb;
  int     mf;
  exp_t   me;
  bit     macc;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete();
      exp_ready = 1'b0;
      exp_stf   = 0;
    end else begin
      macc    = req_valid && exp_ready && (req_op != 2'd3);
      exp_stf = 0;
      stf_lab = "R8";
      if (macc) begin
        mw = (req_op == 2'd1) ? longint'($signed(req_base)) + longint'($signed(req_imm))
                              : longint'(req_imm);
        mb = mw * 4;
        mf = (mb < 0) ? 1 : (mb >= SIZE) ? 2 : 0;
        if (req_op == 2'd2) begin
          exp_stf = mf;
          stf_lab = scen;
          if (mf == 0) mm[int'(mw)] = req_wdata;
        end else begin
          me.due   = cyc + LAT - 1;
          me.tag   = int'(req_tag);
          me.flt   = mf;
          me.known = (mf != 0) || mm.exists(int'(mw));
          me.data  = (mf != 0) ? 32'd0 : (mm.exists(int'(mw)) ? mm[int'(mw)] : 32'd0);
          me.lab   = scen;
          q.push_back(me);
        end
      end
      exp_ready = 1'b1;
    end
  end

  // Comparison at the falling edge.
  exp_t ce;
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(!req_ready && !rsp_valid && st_fault == 2'd0, "R13", "outputs in reset",
            {req_ready, rsp_valid, st_fault}, 0);
      end else begin
        chk(req_ready == exp_ready, "R13", "req_ready", req_ready, exp_ready);
        chk(st_fault == 2'(exp_stf), stf_lab, "st_fault (R8)", st_fault, exp_stf);
        if (q.size() > 0 && q[0].due == cyc) begin
          ce = q.pop_front();
          chk(rsp_valid, ce.lab, "rsp_valid at latency (R4)", rsp_valid, 1);
          chk(rsp_tag == TW'(ce.tag), ce.lab, "rsp_tag order (R5)", rsp_tag, ce.tag);
          chk(rsp_fault == 2'(ce.flt), ce.lab, "rsp_fault", rsp_fault, ce.flt);
          if (ce.known)
            chk(rsp_data == ce.data, ce.lab, "rsp_data", rsp_data, ce.data);
        end else begin
          chk(!rsp_valid, scen, "no response expected (R4)", rsp_valid, 0);
        end
      end
    end
  end

  task automatic put(input int op, input int imm, input int base,
                     input logic [31:0] wd, input int tag);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_imm   = 16'(imm);
    req_base  = 32'(base);
    req_wdata = wd;
    req_tag   = TW'(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    scen = "R3";  // sixteen words across all banks, then read back
    for (int w = 0; w < 16; w++) put(2, w, 0, pat(w), 0);
    for (int w = 0; w < 16; w++) put(0, w, 0, 32'd0, w);
    idle(8);

    scen = "R1";
    put(2, WORDS - 1, 0, pat(WORDS - 1), 0);
    put(0, WORDS - 1, 0, 32'd0, 2);
    put(2, 100, 0, pat(100), 0);
    idle(3);
    put(0, 100, 0, 32'd0, 3);
    idle(8);

    scen = "R2";
    put(1, 16'hFFFD, 10, 32'd0, 4);    // word 7
    put(1, 23, 1000, 32'd0, 5);        // word 1023
    put(1, 0, 100, 32'd0, 6);          // word 100
    idle(8);

    scen = "R6";
    put(1, 16'hFFFF, 0, 32'd0, 7);     // word -1
    put(1, 2, -5, 32'd0, 8);           // word -3
    put(1, 16'h8000, 0, 32'd0, 9);     // word -32768
    idle(8);

    scen = "R7";
    put(0, WORDS, 0, 32'd0, 10);
    put(0, 16'hFFFF, 0, 32'd0, 11);
    put(1, 0, 2000, 32'd0, 12);
    put(1, 1, WORDS - 1, 32'd0, 13);
    idle(8);

    scen = "R8";
    put(2, WORDS, 0, 32'hDEAD_BEEF, 0);
    idle(1);
    put(2, 16'hFFFF, 0, 32'hBAD0_0001, 0);
    idle(2);

    scen = "R9";  // word 0 and word 8 share bank 0; must be untouched
    put(0, 0, 0, 32'd0, 14);
    put(0, 8, 0, 32'd0, 15);
    idle(8);

    scen = "R11";
    put(2, 5, 0, 32'hAAAA_0005, 0);
    put(0, 5, 0, 32'd0, 16);
    put(0, 5, 0, 32'd0, 17);
    put(2, 5, 0, 32'hBBBB_0005, 0);
    put(0, 5, 0, 32'd0, 18);
    idle(8);

    scen = "R12";
    put(3, 6, 0, 32'h1234_5678, 19);
    idle(8);
    put(0, 6, 0, 32'd0, 20);
    idle(8);

    scen = "R10";
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    for (int w = 0; w < 4; w++) put(0, w, 0, 32'd0, 21 + w);
    idle(8);

    scen = "R5";
    put(0, 9, 0, 32'd0, 31);
    idle(1);
    put(1, 3, 10, 32'd0, 17);
    put(0, WORDS, 0, 32'd0, 0);
    idle(2);
    put(0, 12, 0, 32'd0, 29);
    idle(10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule